// File: doc/BRIEF.md
# Warp Memory Access Coalescer

This block takes one load request from a group of lanes that execute together. Each lane supplies a byte address and reads one 4-byte word, and a mask marks which lanes take part. Memory can only be fetched in whole 128-byte slots whose base addresses are multiples of 128, so the block works out which slots the active lanes touch. It then issues one transaction per distinct slot. Each transaction carries the slot base address and a bitmask of the lanes that slot serves.

Transactions leave one per cycle under a valid/ready handshake, lowest base address first. After the last one is accepted, a one-cycle report gives the transaction count, the useful bytes and the bytes moved. Useful bytes over moved bytes is the efficiency of the request. Cost follows the number of slots touched, not the number of lanes. A start that is not aligned to a slot, or a wide stride between lanes, multiplies it. The lane count must be a power of two.

Top module: `warp_coalescer`

## Requirements
- R1: Every transaction base is a multiple of 128 and equals the address, with its low 7 bits cleared, of each lane in its lane mask.
- R2: Bit i of a transaction's lane mask is set exactly when lane i is active and its address falls in that slot. Every active lane appears in exactly one transaction of its request.
- R3: The number of transactions equals the number of distinct slots touched by active lanes. Lanes at byte addresses 4*i give one transaction. So does a contiguous run that crosses a logical matrix row boundary but stays within one slot.
- R4: Lanes at byte addresses 4+4*i (bytes 4 to 131) give exactly two transactions, with bases 0 and 128.
- R5: Lanes at stride 128 bytes, or at stride 1000 bytes, give 32 transactions.
- R6: Lanes whose mask bit is 0 have no effect on the transactions. A request with an all-zero mask issues no transaction and reports a count of 0.
- R7: Transactions come out in strictly ascending base order, at most one per cycle. While txn_valid is high and txn_ready is low, base, lanes and last hold steady.
- R8: One cycle after the final transaction is accepted (or one cycle after accepting an empty request), done_valid is high for exactly one cycle. It reports done_txns = count, done_useful = 4 × active lanes and done_moved = 128 × count.
- R9: req_ready is high only while idle, and a request is taken on req_valid && req_ready. The first transaction is valid in the cycle that follows. The final transaction has txn_last set.
- R10: The two low address bits of each lane do not affect grouping. A word is treated as lying wholly in the slot of its address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to take a request |
| req_addr | input | LANES*ADDR_W | Byte address per lane, lane i at bits [i*ADDR_W +: ADDR_W] |
| req_mask | input | LANES | Active-lane mask, bit i for lane i |
| txn_valid | output | 1 | Transaction present |
| txn_ready | input | 1 | Downstream accepts the transaction |
| txn_base | output | ADDR_W | Slot base address |
| txn_lanes | output | LANES | Lanes served by this slot |
| txn_last | output | 1 | Final transaction of the request |
| done_valid | output | 1 | One-cycle report pulse |
| done_txns | output | $clog2(LANES+1) | Transactions issued |
| done_useful | output | $clog2(LANES*SEG_BYTES+1) | Bytes the lanes use |
| done_moved | output | $clog2(LANES*SEG_BYTES+1) | Bytes transferred |

## Verification
Two things can land in the same cycle: the downstream stall on a transaction, and that transaction being the final one with txn_last set, which is what moves the block into its report. The bench drives txn_ready with random gaps across many strides and offsets, so the final transaction is often held for several cycles. A held beat is judged by comparing base, lanes and last against the expected slot in every cycle. done_valid must appear only in the cycle after the last beat is really taken, with a count that matches the number of beats seen.

// File: rtl/coal_pkg.sv
package coal_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ISSUE  = 2'd1,
        ST_REPORT = 2'd2
    } coal_state_e;

endpackage

// File: rtl/coal_popcnt.sv
module coal_popcnt #(
    parameter int W     = 32,
    parameter int OUT_W = $clog2(W + 1)
) (
    input  logic [W-1:0]     bits,
    output logic [OUT_W-1:0] ones
);

    always_comb begin
        ones = '0;
        for (int i = 0; i < W; i++) begin
            ones = ones + OUT_W'(bits[i]);
        end
    end

endmodule

// File: rtl/coal_min_tree.sv
// Finds the lowest slot number among the live lanes with a balanced tree
// of compare-select nodes. Level 0 holds the lanes; each higher level halves.
module coal_min_tree #(
    parameter int LANES = 32,
    parameter int SEG_W = 25
) (
    input  logic [LANES-1:0]       live,
    input  logic [LANES*SEG_W-1:0] segs,
    output logic                   any_live,
    output logic [SEG_W-1:0]       min_seg
);

    localparam int LVLS  = $clog2(LANES);
    localparam int NODES = 2 * LANES - 1;

    logic             nv [NODES];
    logic [SEG_W-1:0] ns [NODES];

    for (genvar k = 0; k < LANES; k++) begin : g_leaf
        assign nv[k] = live[k];
        assign ns[k] = segs[k*SEG_W +: SEG_W];
    end

    for (genvar l = 1; l <= LVLS; l++) begin : g_lvl
        localparam int CNT  = LANES >> l;
        localparam int BASE = 2 * LANES - (2 * LANES >> l);
        localparam int PREV = 2 * LANES - (2 * LANES >> (l - 1));
        for (genvar k = 0; k < CNT; k++) begin : g_node
            logic pick_left;
            assign pick_left = nv[PREV+2*k] &&
                               (!nv[PREV+2*k+1] || (ns[PREV+2*k] <= ns[PREV+2*k+1]));
            assign nv[BASE+k] = nv[PREV+2*k] | nv[PREV+2*k+1];
            assign ns[BASE+k] = pick_left ? ns[PREV+2*k] : ns[PREV+2*k+1];
        end
    end

    assign any_live = nv[NODES-1];
    assign min_seg  = ns[NODES-1];

endmodule

// File: rtl/coal_seg_match.sv
module coal_seg_match #(
    parameter int LANES = 32,
    parameter int SEG_W = 25
) (
    input  logic [LANES-1:0]       live,
    input  logic [LANES*SEG_W-1:0] segs,
    input  logic [SEG_W-1:0]       target,
    output logic [LANES-1:0]       hit
);

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        assign hit[k] = live[k] && (segs[k*SEG_W +: SEG_W] == target);
    end

endmodule

// File: rtl/warp_coalescer.sv
module warp_coalescer
    import coal_pkg::*;
#(
    parameter int LANES      = 32,
    parameter int ADDR_W     = 32,
    parameter int SEG_BYTES  = 128,
    parameter int WORD_BYTES = 4,
    parameter int CNT_W      = $clog2(LANES + 1),
    parameter int BYTE_W     = $clog2(LANES * SEG_BYTES + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    output logic                    req_ready,
    input  logic [LANES*ADDR_W-1:0] req_addr,
    input  logic [LANES-1:0]        req_mask,
    output logic                    txn_valid,
    input  logic                    txn_ready,
    output logic [ADDR_W-1:0]       txn_base,
    output logic [LANES-1:0]        txn_lanes,
    output logic                    txn_last,
    output logic                    done_valid,
    output logic [CNT_W-1:0]        done_txns,
    output logic [BYTE_W-1:0]       done_useful,
    output logic [BYTE_W-1:0]       done_moved
);

    localparam int OFF_W = $clog2(SEG_BYTES);
    localparam int SEG_W = ADDR_W - OFF_W;

    typedef struct packed {
        coal_state_e              state;
        logic [LANES*SEG_W-1:0]   segs;
        logic [LANES-1:0]         pending;
        logic [CNT_W-1:0]         count;
        logic [CNT_W-1:0]         active;
    } coal_regs_t;

    coal_regs_t r_d, r_q;

    // Slot number of each lane; offset bits inside a slot do not group lanes.
    logic [LANES*SEG_W-1:0] req_segs;
    logic [LANES*OFF_W-1:0] req_offs;
    logic                   lane_offsets_unused;

    for (genvar g = 0; g < LANES; g++) begin : g_split
        assign req_segs[g*SEG_W +: SEG_W] = req_addr[g*ADDR_W + OFF_W +: SEG_W];
        assign req_offs[g*OFF_W +: OFF_W] = req_addr[g*ADDR_W +: OFF_W];
    end
    assign lane_offsets_unused = ^req_offs;

    logic [CNT_W-1:0] req_active;

    coal_popcnt #(.W(LANES), .OUT_W(CNT_W)) u_popcnt (
        .bits (req_mask),
        .ones (req_active)
    );

    logic             any_live;
    logic [SEG_W-1:0] low_seg;
    logic [LANES-1:0] low_hit;
    logic [LANES-1:0] remaining;

    coal_min_tree #(.LANES(LANES), .SEG_W(SEG_W)) u_min (
        .live     (r_q.pending),
        .segs     (r_q.segs),
        .any_live (any_live),
        .min_seg  (low_seg)
    );

    coal_seg_match #(.LANES(LANES), .SEG_W(SEG_W)) u_match (
        .live   (r_q.pending),
        .segs   (r_q.segs),
        .target (low_seg),
        .hit    (low_hit)
    );

    assign remaining = r_q.pending & ~low_hit;

    always_comb begin
        r_d = r_q;
        unique case (r_q.state)
            ST_IDLE: begin
                if (req_valid) begin
                    r_d.segs    = req_segs;
                    r_d.pending = req_mask;
                    r_d.count   = '0;
                    r_d.active  = req_active;
                    r_d.state   = (req_mask != '0) ? ST_ISSUE : ST_REPORT;
                end
            end
            ST_ISSUE: begin
                if (txn_ready && any_live) begin
                    r_d.pending = remaining;
                    r_d.count   = r_q.count + CNT_W'(1);
                    if (remaining == '0) begin
                        r_d.state = ST_REPORT;
                    end
                end
            end
            ST_REPORT: begin
                r_d.state = ST_IDLE;
            end
            default: begin
                r_d.state = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign req_ready   = (r_q.state == ST_IDLE);
    assign txn_valid   = (r_q.state == ST_ISSUE) && any_live;
    assign txn_base    = {low_seg, {OFF_W{1'b0}}};
    assign txn_lanes   = low_hit;
    assign txn_last    = (remaining == '0);
    assign done_valid  = (r_q.state == ST_REPORT);
    assign done_txns   = r_q.count;
    assign done_useful = BYTE_W'(r_q.active) * BYTE_W'(WORD_BYTES);
    assign done_moved  = BYTE_W'(r_q.count) * BYTE_W'(SEG_BYTES);

    // R2: an offered transaction always serves at least one lane
    p_lanes_nonempty_r2: assert property (@(posedge clk) disable iff (!rst_n)
        txn_valid |-> (txn_lanes != '0));

    // R2: the report only follows once every active lane was served
    p_all_served_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |-> (r_q.pending == '0));

    // R7: bases rise strictly within one request
    p_ascending_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (txn_valid && txn_ready && !txn_last) |=> (txn_valid && (txn_base > $past(txn_base))));

    // R7: a stalled beat holds its content
    p_stall_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (txn_valid && !txn_ready) |=> (txn_valid && $stable(txn_base) && $stable(txn_lanes)));

    // R8: useful bytes never exceed moved bytes
    p_eff_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |-> (done_useful <= done_moved));

    // R8: the report lasts one cycle
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |=> !done_valid);

    // R9: no new request while transactions are pending
    p_busy_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
        txn_valid |-> !req_ready);

endmodule

// File: tb/warp_coalescer_tb.sv
`timescale 1ns/1ps
module warp_coalescer_tb;

    localparam int LANES  = 32;
    localparam int ADDR_W = 32;

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic                    req_valid = 1'b0;
    logic                    req_ready;
    logic [LANES*ADDR_W-1:0] req_addr = '0;
    logic [LANES-1:0]        req_mask = '0;
    logic                    txn_valid;
    logic                    txn_ready = 1'b0;
    logic [ADDR_W-1:0]       txn_base;
    logic [LANES-1:0]        txn_lanes;
    logic                    txn_last;
    logic                    done_valid;
    logic [5:0]              done_txns;
    logic [12:0]             done_useful;
    logic [12:0]             done_moved;

    warp_coalescer u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_mask(req_mask),
        .txn_valid(txn_valid), .txn_ready(txn_ready),
        .txn_base(txn_base), .txn_lanes(txn_lanes), .txn_last(txn_last),
        .done_valid(done_valid), .done_txns(done_txns),
        .done_useful(done_useful), .done_moved(done_moved)
    );

    always #4 clk = ~clk;

    int vectors = 0;
    int misses  = 0;

    logic [31:0] t_addr [LANES];
    logic [31:0] t_mask;
    logic [31:0] e_base  [LANES];
    logic [31:0] e_lanes [LANES];
    int          e_n;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        vectors++;
        if (!ok) begin
            misses++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // Expected slots: repeatedly take the lowest untouched slot of the active lanes.
    task automatic build_expect();
        logic [31:0] rem;
        logic [31:0] lo;
        logic [31:0] grp;
        rem = t_mask;
        e_n = 0;
        while (rem != 0) begin
            lo = 32'hFFFF_FFFF;
            for (int i = 0; i < LANES; i++)
                if (rem[i] && ((t_addr[i] >> 7) <= lo)) lo = t_addr[i] >> 7;
            grp = 0;
            for (int i = 0; i < LANES; i++)
                if (rem[i] && ((t_addr[i] >> 7) == lo)) grp[i] = 1'b1;
            e_base[e_n]  = lo << 7;
            e_lanes[e_n] = grp;
            e_n++;
            rem = rem & ~grp;
        end
    endtask

    task automatic run_req(input string tag, input int want_n);
        int  k;
        int  pops;
        bit  finished;
        build_expect();
        pops = $countones(t_mask);
        @(negedge clk);
        req_valid = 1'b1;
        req_mask  = t_mask;
        for (int i = 0; i < LANES; i++) req_addr[i*ADDR_W +: ADDR_W] = t_addr[i];
        #1;
        while (!req_ready) begin
            @(negedge clk);
            #1;
        end
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        k = 0;
        finished = 1'b0;
        // R9: first beat (or report for an empty mask) in the cycle after acceptance
        #1;
        if (e_n > 0) check(txn_valid === 1'b1, {"R9 first beat ", tag}, txn_valid, 1);
        else         check(done_valid === 1'b1, {"R6 empty report ", tag}, done_valid, 1);
        for (int cyc = 0; cyc < 400 && !finished; cyc++) begin
            txn_ready = ($urandom % 4) != 0;
            #1;
            check(req_ready === 1'b0, {"R9 busy ", tag}, req_ready, 0);
            if (done_valid) begin
                check(done_txns == 6'(e_n), {"R3 count ", tag}, done_txns, e_n);
                check(done_useful == 13'(4 * pops), {"R8 useful ", tag}, done_useful, 4 * pops);
                check(done_moved == 13'(128 * e_n), {"R8 moved ", tag}, done_moved, 128 * e_n);
                check(k == e_n, {"R8 report after last beat ", tag}, k, e_n);
                if (want_n >= 0)
                    check(done_txns == 6'(want_n), {"R3/R4/R5/R6 literal ", tag}, done_txns, want_n);
                finished = 1'b1;
            end else if (txn_valid) begin
                if (k >= e_n) begin
                    check(1'b0, {"R3 extra beat ", tag}, k, e_n);
                end else begin
                    check(txn_base == e_base[k], {"R1 base ", tag}, txn_base, e_base[k]);
                    check(txn_lanes == e_lanes[k], {"R2 lanes ", tag}, txn_lanes, e_lanes[k]);
                    check(txn_last == (k == e_n - 1), {"R9 last ", tag}, txn_last, k == e_n - 1);
                    if (txn_ready) k++;
                end
            end
            @(negedge clk);
        end
        check(finished, {"R8 report seen ", tag}, finished, 1);
        @(negedge clk);
        #1;
        check(done_valid === 1'b0, {"R8 one-cycle report ", tag}, done_valid, 0);
    endtask

    initial begin
        #2_000_000;
        misses++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        check(req_ready === 1'b1, "R9 reset idle", req_ready, 1);
        check(txn_valid === 1'b0, "R9 reset no beat", txn_valid, 0);
        check(done_valid === 1'b0, "R8 reset no report", done_valid, 0);

        t_mask = 32'hFFFF_FFFF;
        for (int i = 0; i < LANES; i++) t_addr[i] = 32'(4 * i);
        run_req("R3 sequential", 1);

        for (int i = 0; i < LANES; i++) t_addr[i] = 32'(4 + 4 * i);
        run_req("R4 shifted by 4", 2);

        for (int i = 0; i < LANES; i++) t_addr[i] = 32'(128 * i);
        run_req("R5 column stride 128", 32);

        for (int i = 0; i < LANES; i++) t_addr[i] = 32'(1000 * i);
        run_req("R5 stride 1000", 32);

        // Rows of 16 words: lanes 0-15 row 0, lanes 16-31 row 1, one slot.
        for (int i = 0; i < LANES; i++) t_addr[i] = 32'(64 * (i / 16) + 4 * (i % 16) + 512);
        run_req("R3 two rows one slot", 1);

        t_mask = 32'h0;
        run_req("R6 empty mask", 0);

        t_mask = 32'h0000_FFFF;
        for (int i = 0; i < LANES; i++) t_addr[i] = (i < 16) ? 32'(4 * i) : 32'(4096 * i);
        run_req("R6 inactive far lanes", 1);

        t_mask = 32'hFFFF_FFFF;
        for (int i = 0; i < LANES; i++) t_addr[i] = 32'(128 * (31 - i) + 8);
        run_req("R7 descending lanes", 32);

        for (int i = 0; i < LANES; i++) t_addr[i] = 32'(4 * i + 3);
        run_req("R10 low bits set", 1);

        for (int i = 0; i < LANES; i++) t_addr[i] = 32'h0000_1234;
        run_req("R3 same address", 1);

        for (int i = 0; i < LANES; i++) t_addr[i] = 32'hFFFF_FF80 + 32'(4 * i);
        run_req("R1 top slot", 1);

        // Sweep: word stride 0..40, word offsets, varied masks
        for (int s = 0; s <= 40; s++) begin
            for (int o = 0; o < 32; o += 3) begin
                t_mask = ((s + o) % 3 == 0) ? 32'hFFFF_FFFF : $urandom;
                for (int i = 0; i < LANES; i++) t_addr[i] = 32'(4 * o + 4 * s * i + 256 * s);
                run_req("R3 sweep", -1);
            end
        end

        // Scattered addresses within a small window to force partial merges
        for (int n = 0; n < 200; n++) begin
            t_mask = $urandom;
            for (int i = 0; i < LANES; i++) t_addr[i] = $urandom % 2048;
            run_req("R2 scatter", -1);
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

endmodule